// File: doc/BRIEF.md
# Board Interconnect Test Pattern Generator and Classifier

This block drives a set of board nets with a coded test sequence through boundary scan cells and diagnoses the responses that come back. Each net gets its own binary code. One bit of every code is applied per test step, so each step produces a parallel vector across all nets. After the last step the block compares what each net returned against what it was sent. It then marks every net as good, as a suspected open, or as a member of a suspected short.

The fault models are fixed. A short joins its nets as a wired AND of their driven values. An open reads back as a constant zero. Net `i` carries base code `i+1`, which is `CW = ceil(log2(NETS+2))` bits wide. This choice means no net's base code is all zeros or all ones, both of which would look like a stuck line. One parity step is added after the base steps to sharpen the diagnosis. A run is started with a pulse on `start`. The serial shifting through the scan chain belongs to a separate controller, so this block only sees parallel vectors.

Top module: `ict_gen`

## Requirements
- R1: While reset is low and after it, until the first start: `busy`, `done`, `step`, `drive` and all three status vectors are zero.
- R2: A `start` pulse while idle or done begins a run of `STEPS = CW+1` apply cycles. `step` reads 0 in the first cycle and rises by one each cycle up to `STEPS-1`, with `busy` high.
- R3: During the cycle in which `step` reads `k`, `drive[i]` equals bit `k` of net `i`'s extended code. Bits `0..CW-1` of that code hold `i+1`, and bit `CW` holds the XOR of those base bits.
- R4: `drive` is all zeros whenever no apply step is in progress.
- R5: Across the steps, no two nets are driven with the same code, and no net's base bits are all zeros or all ones.
- R6: `done` rises in the second cycle after the last apply step, one evaluation cycle in between with `busy` still high. From then on `done` and the status vectors hold their values until the next start.
- R7: `net_good[i]` is set when the response captured from net `i` over all steps equals its extended code.
- R8: `net_open[i]` is set when every response bit captured from net `i` is zero.
- R9: `net_short[i]` is set when net `i`'s response is neither its own code nor all zeros, and equals the response of at least one other net.
- R10: A `start` pulse while a run is in progress has no effect. The run keeps its step sequence and ends with the same result.
- R11: A start accepted while done clears `done` and all status vectors in the cycle after it is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begins a run when idle or done |
| capture | input | NETS | Response vector read back from the nets, sampled each apply step |
| drive | output | NETS | Test vector to be applied to the nets |
| step | output | clog2(STEPS) | Index of the current apply step |
| busy | output | 1 | Run in progress (apply or evaluation) |
| done | output | 1 | Results valid |
| net_good | output | NETS | Net returned its own code |
| net_open | output | NETS | Net returned all zeros |
| net_short | output | NETS | Net returned a foreign code shared with another net |

## Verification
A wrong step counter or a corrupted code table shows up on `drive` in the same cycle. The bench compares every vector against codes it builds itself. A response bit stored in the wrong place, or a fault in the classification logic, appears only when `done` rises, two cycles after the last step. It shows as a misplaced good, open or short flag. For this reason the fault patterns include opens, pairs, triples and mixed cases, so that each class gets both set and cleared. A state machine that leaves the done state too early, or lets a mid-run start restart the run, shows as a broken step sequence or as flags that change while `start` is low.

// File: rtl/ict_pkg.sv
package ict_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_APPLY = 2'd1,
    ST_EVAL  = 2'd2,
    ST_DONE  = 2'd3
  } ict_state_e;

  // Extended code of one net: base value net+1 in bits [cw-1:0],
  // parity of the base bits in bit cw.
  function automatic logic [31:0] ict_ext_code(input int unsigned net,
                                               input int unsigned cw);
    logic [31:0] base;
    logic        par;
    base = 32'(net + 1);
    par  = ^base;
    return base | (32'(par) << cw);
  endfunction

endpackage

// File: rtl/ict_seq.sv
module ict_seq
  import ict_pkg::*;
#(
  parameter int STEPS = 5,
  parameter int SW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  output logic [SW-1:0] step,
  output logic          applying,
  output logic          eval_now,
  output logic          done_st,
  output logic          accept,
  output logic          last_step
);

  localparam logic [SW-1:0] LAST = SW'(STEPS - 1);

  ict_state_e state;

  assign applying  = (state == ST_APPLY);
  assign eval_now  = (state == ST_EVAL);
  assign done_st   = (state == ST_DONE);
  assign last_step = applying && (step == LAST);
  assign accept    = start && ((state == ST_IDLE) || (state == ST_DONE));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      step  <= '0;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: begin
          if (start) begin
            state <= ST_APPLY;
            step  <= '0;
          end
        end
        ST_APPLY: begin
          if (step == LAST) begin
            state <= ST_EVAL;
            step  <= '0;
          end else begin
            step <= step + 1'b1;
          end
        end
        ST_EVAL: state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ict_pattern.sv
module ict_pattern
  import ict_pkg::*;
#(
  parameter int NETS  = 8,
  parameter int CW    = 4,
  parameter int STEPS = 5,
  parameter int SW    = 3
) (
  input  logic            applying,
  input  logic [SW-1:0]   step,
  output logic [NETS-1:0] drive
);

  for (genvar g = 0; g < NETS; g++) begin : g_net
    localparam logic [STEPS-1:0] CODE = STEPS'(ict_ext_code(g, CW));
    assign drive[g] = applying & CODE[step];
  end

endmodule

// File: rtl/ict_capture.sv
module ict_capture #(
  parameter int NETS  = 8,
  parameter int STEPS = 5,
  parameter int SW    = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clear,
  input  logic                  applying,
  input  logic [SW-1:0]         step,
  input  logic [NETS-1:0]       capture,
  output logic [NETS*STEPS-1:0] resp
);

  for (genvar g = 0; g < NETS; g++) begin : g_net
    logic [STEPS-1:0] row;
    always_ff @(posedge clk) begin
      if (!rst_n || clear) begin
        row <= '0;
      end else if (applying) begin
        row[step] <= capture[g];
      end
    end
    assign resp[g*STEPS +: STEPS] = row;
  end

endmodule

// File: rtl/ict_classify.sv
module ict_classify
  import ict_pkg::*;
#(
  parameter int NETS  = 8,
  parameter int CW    = 4,
  parameter int STEPS = 5
) (
  input  logic [NETS*STEPS-1:0] resp,
  output logic [NETS-1:0]       cls_good,
  output logic [NETS-1:0]       cls_open,
  output logic [NETS-1:0]       cls_short
);

  for (genvar i = 0; i < NETS; i++) begin : g_net
    localparam logic [STEPS-1:0] EXP = STEPS'(ict_ext_code(i, CW));
    logic [STEPS-1:0] rx;
    logic [NETS-1:0]  peer;
    assign rx = resp[i*STEPS +: STEPS];
    for (genvar j = 0; j < NETS; j++) begin : g_peer
      if (j == i) begin : g_self
        assign peer[j] = 1'b0;
      end else begin : g_other
        assign peer[j] = (resp[j*STEPS +: STEPS] == rx);
      end
    end
    assign cls_good[i]  = (rx == EXP);
    assign cls_open[i]  = (rx == '0);
    assign cls_short[i] = !cls_good[i] && !cls_open[i] && (|peer);
  end

endmodule

// File: rtl/ict_gen.sv
module ict_gen
  import ict_pkg::*;
#(
  parameter int NETS = 8,
  localparam int CW    = $clog2(NETS + 2),
  localparam int STEPS = CW + 1,
  localparam int SW    = (STEPS > 1) ? $clog2(STEPS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [NETS-1:0] capture,
  output logic [NETS-1:0] drive,
  output logic [SW-1:0]   step,
  output logic            busy,
  output logic            done,
  output logic [NETS-1:0] net_good,
  output logic [NETS-1:0] net_open,
  output logic [NETS-1:0] net_short
);

  logic                  seq_applying;
  logic                  seq_eval;
  logic                  seq_done;
  logic                  seq_accept;
  logic                  seq_last;
  logic [NETS*STEPS-1:0] resp_vec;
  logic [NETS-1:0]       cls_good;
  logic [NETS-1:0]       cls_open;
  logic [NETS-1:0]       cls_short;

  ict_seq #(.STEPS(STEPS), .SW(SW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .step      (step),
    .applying  (seq_applying),
    .eval_now  (seq_eval),
    .done_st   (seq_done),
    .accept    (seq_accept),
    .last_step (seq_last)
  );

  ict_pattern #(.NETS(NETS), .CW(CW), .STEPS(STEPS), .SW(SW)) u_pat (
    .applying (seq_applying),
    .step     (step),
    .drive    (drive)
  );

  ict_capture #(.NETS(NETS), .STEPS(STEPS), .SW(SW)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (seq_accept),
    .applying (seq_applying),
    .step     (step),
    .capture  (capture),
    .resp     (resp_vec)
  );

  ict_classify #(.NETS(NETS), .CW(CW), .STEPS(STEPS)) u_cls (
    .resp      (resp_vec),
    .cls_good  (cls_good),
    .cls_open  (cls_open),
    .cls_short (cls_short)
  );

  always_ff @(posedge clk) begin
    if (!rst_n || seq_accept) begin
      net_good  <= '0;
      net_open  <= '0;
      net_short <= '0;
    end else if (seq_eval) begin
      net_good  <= cls_good;
      net_open  <= cls_open;
      net_short <= cls_short;
    end
  end

  assign busy = seq_applying | seq_eval;
  assign done = seq_done;

endmodule

// File: rtl/ict_gen_chk.sv
module ict_gen_chk #(
  parameter int NETS  = 8,
  parameter int STEPS = 5,
  parameter int SW    = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            start,
  input logic [NETS-1:0] drive,
  input logic [SW-1:0]   step,
  input logic            busy,
  input logic            done,
  input logic [NETS-1:0] net_good,
  input logic [NETS-1:0] net_open,
  input logic [NETS-1:0] net_short,
  input logic            applying,
  input logic            eval_now,
  input logic            last_step
);

  // R4
  drive_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (drive == '0));

  // R2
  step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (applying && !last_step) |=> (applying && (step == SW'($past(step) + 1'b1))));

  // R6
  done_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(eval_now));

  // R6
  eval_to_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eval_now |=> (done && !busy));

  // R6
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(net_good) && $stable(net_open)
                          && $stable(net_short)));

  // R10
  run_continues_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (applying && !last_step && start) |=> applying);

  // R11
  restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && start) |=> (!done && busy && (net_good == '0) && (net_open == '0)
                         && (net_short == '0)));

  for (genvar i = 0; i < NETS; i++) begin : g_excl
    // R7 R8 R9
    class_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({net_good[i], net_open[i], net_short[i]}));
  end

endmodule

bind ict_gen ict_gen_chk #(.NETS(NETS), .STEPS(STEPS), .SW(SW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .drive     (drive),
  .step      (step),
  .busy      (busy),
  .done      (done),
  .net_good  (net_good),
  .net_open  (net_open),
  .net_short (net_short),
  .applying  (seq_applying),
  .eval_now  (seq_eval),
  .last_step (seq_last)
);

// File: tb/ict_gen_test.sv
`timescale 1ns/1ps
module ict_gen_test;
  localparam int NETS  = 8;
  localparam int CW    = $clog2(NETS + 2);
  localparam int STEPS = CW + 1;
  localparam int SW    = $clog2(STEPS);

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [NETS-1:0] capture;
  logic [NETS-1:0] drive;
  logic [SW-1:0]   step;
  logic            busy, done;
  logic [NETS-1:0] net_good, net_open, net_short;

  int errors = 0;
  int checks = 0;
  int cycles = 0;
  int grp[NETS];
  bit opn[NETS];
  int seen[NETS];

  always #2.5 clk = ~clk;

  ict_gen #(.NETS(NETS)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .capture(capture),
    .drive(drive), .step(step), .busy(busy), .done(done),
    .net_good(net_good), .net_open(net_open), .net_short(net_short)
  );

  // board fault model: wired AND inside a group, opens read zero
  always_comb begin
    logic v;
    for (int i = 0; i < NETS; i++) begin
      v = drive[i];
      if (grp[i] != 0)
        for (int j = 0; j < NETS; j++)
          if (grp[j] == grp[i]) v = v & drive[j];
      if (opn[i]) v = 1'b0;
      capture[i] = v;
    end
  end

  function automatic int ref_code(int i);
    int b = i + 1;
    int p = 0;
    for (int k = 0; k < CW; k++) p = p ^ ((b >> k) & 1);
    return b | (p << CW);
  endfunction

  task automatic chk(bit ok, string req, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=<100000 cycles", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic clear_faults();
    for (int i = 0; i < NETS; i++) begin grp[i] = 0; opn[i] = 0; end
  endtask

  task automatic run_case(bit mid_start);
    int rx[NETS];
    logic [NETS-1:0] eg, eo, es, ev;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    // R11 statuses cleared on restart; R2 first step
    chk(!done && net_good == 0 && net_open == 0 && net_short == 0, "R11",
        {done, net_good}, 0);
    chk(busy && step == 0, "R2", step, 0);
    for (int k = 0; k < STEPS; k++) begin
      if (k > 0) @(negedge clk);
      if (mid_start && k == 1) start = 1'b1;
      if (mid_start && k == 2) start = 1'b0;
      chk(busy && step == SW'(k), "R2", step, k);
      for (int i = 0; i < NETS; i++) ev[i] = (ref_code(i) >> k) & 1;
      chk(drive == ev, "R3", drive, ev);
      for (int i = 0; i < NETS; i++)
        if (drive[i]) seen[i] = seen[i] | (1 << k);
        else seen[i] = seen[i] & ~(1 << k);
    end
    start = 1'b0;
    @(negedge clk);
    chk(busy && !done, "R6", {busy, done}, 2'b10);
    chk(drive == 0, "R4", drive, 0);
    @(negedge clk);
    chk(done && !busy, "R6", {busy, done}, 2'b01);
    if (mid_start) chk(done, "R10", done, 1);
    for (int i = 0; i < NETS; i++) begin
      if (opn[i]) rx[i] = 0;
      else begin
        rx[i] = ref_code(i);
        if (grp[i] != 0)
          for (int j = 0; j < NETS; j++)
            if (grp[j] == grp[i]) rx[i] = rx[i] & ref_code(j);
      end
    end
    for (int i = 0; i < NETS; i++) begin
      eg[i] = (rx[i] == ref_code(i));
      eo[i] = (rx[i] == 0);
      es[i] = 1'b0;
      if (!eg[i] && !eo[i])
        for (int j = 0; j < NETS; j++)
          if (j != i && rx[j] == rx[i]) es[i] = 1'b1;
    end
    chk(net_good == eg, "R7", net_good, eg);
    chk(net_open == eo, "R8", net_open, eo);
    chk(net_short == es, "R9", net_short, es);
    repeat (3) @(negedge clk);
    chk(done && net_good == eg && net_open == eo && net_short == es, "R6",
        {net_good, net_open, net_short}, {eg, eo, es});
    chk(drive == 0, "R4", drive, 0);
  endtask

  initial begin
    bit uniq;
    void'($urandom(32'd7719));
    clear_faults();
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !done && step == 0 && drive == 0 && net_good == 0
        && net_open == 0 && net_short == 0, "R1", {busy, done, drive}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !done && drive == 0, "R1", {busy, done, drive}, 0);

    run_case(0);
    // R5 codes unique, base never all zeros or all ones
    uniq = 1'b1;
    for (int i = 0; i < NETS; i++) begin
      if ((seen[i] & ((1 << CW) - 1)) == 0) uniq = 0;
      if ((seen[i] & ((1 << CW) - 1)) == (1 << CW) - 1) uniq = 0;
      for (int j = 0; j < i; j++) if (seen[i] == seen[j]) uniq = 0;
    end
    chk(uniq, "R5", uniq, 1);

    opn[3] = 1; run_case(0); clear_faults();
    grp[1] = 1; grp[2] = 1; run_case(0); clear_faults();
    grp[0] = 2; grp[5] = 2; grp[6] = 2; run_case(0); clear_faults();
    opn[7] = 1; grp[2] = 1; grp[4] = 1; run_case(0); clear_faults();
    grp[0] = 1; grp[2] = 1; run_case(1); clear_faults();  // R10
    for (int n = 0; n < 20; n++) begin
      for (int i = 0; i < NETS; i++) begin
        grp[i] = (($urandom % 4) == 0) ? 1 + ($urandom % 2) : 0;
        opn[i] = (($urandom % 6) == 0);
      end
      run_case(n % 5 == 2);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule